// File: doc/BRIEF.md
# Masked Data Breakpoint Comparator

This block watches the data transfers a processor makes on its local bus and reports when a transfer's operand equals a programmed breakpoint value. Individual bits can be excluded from the comparison through a mask. The bus is 32 bits wide and big-endian. Byte and word operands sit in lanes chosen by the two low address bits and the access size. The block moves the operand out of its lanes and right-justifies it, so the breakpoint value is always programmed as a right-justified number, whatever the offset of the access.

The breakpoint value and the mask are loaded through a one-word register write port. A select bit on that port picks which of the two registers is written. An enable input gates the result. Every qualifying transfer gives a registered match pulse that lasts exactly one clock. The pulse feeds trigger logic that sits outside this block.

Top module: `dbp_match_unit`

## Requirements
- R1: After a synchronous active-low reset the value and mask registers hold zero and `bp_match` is low.
- R2: A longword access (`xfer_size` = 2'b00, and also the unused code 2'b11) compares all 32 bits of `xfer_data` against the value register, whatever `xfer_addr` is.
- R3: A mask bit of 1 makes the matching operand bit don't-care. A mask bit of 0 makes that bit take part in the comparison.
- R4: A word access (`xfer_size` = 2'b10) takes its operand from `xfer_data[31:16]` when `xfer_addr[1]` is 0, and from `xfer_data[15:0]` when it is 1. `xfer_addr[0]` has no effect.
- R5: A byte access (`xfer_size` = 2'b01) takes its operand from bits 31:24, 23:16, 15:8 or 7:0 for `xfer_addr` 0, 1, 2 or 3 respectively.
- R6: A byte operand is compared only against bits 7:0 of the value and mask registers, and a word operand only against bits 15:0. The upper register bits are ignored for these sizes.
- R7: A match is reported only for a cycle in which `xfer_valid` is high. `bp_match` rises in the cycle after that transfer and stays high for exactly one clock for each matching transfer.
- R8: With `wr_en` high, `wr_sel` = 0 loads `wr_data` into the value register and `wr_sel` = 1 loads it into the mask register. The write applies to transfers from the next cycle onward. A transfer in the same cycle as the write still uses the old contents.
- R9: While `bp_enable` is low in the transfer's cycle, no match is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the value register, 1 selects the mask register |
| wr_data | input | 32 | Data to write |
| bp_enable | input | 1 | Allows matches to be reported |
| xfer_valid | input | 1 | A bus transfer is present in this cycle |
| xfer_data | input | 32 | Bus data, big-endian lanes |
| xfer_addr | input | 2 | Low address bits of the transfer |
| xfer_size | input | 2 | 00 longword, 01 byte, 10 word, 11 treated as longword |
| bp_match | output | 1 | One-clock registered match pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit bus of four 8-bit lanes. With these values every lane and every word half can be reached from the two address bits. The random phase programs random masks, with many don't-care bits and many live bits, and about half of the transfers carry data built to match in the selected lane. This exercises both outcomes at every offset and for every size. Random junk in the upper register bits shows that byte and word compares ignore those bits.

// File: rtl/dbp_pkg.sv
// Package dbp_pkg
// Shared bus geometry and access-size encoding for the data breakpoint
// comparator. Assumes a big-endian bus built from equal byte lanes.
package dbp_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = BUS_W / LANE_W;
    localparam int unsigned ADDR_W = $clog2(LANES);

    // Access size codes as seen on xfer_size
    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/dbp_regs.sv
// Module dbp_regs
// Holds the breakpoint value and the breakpoint mask. One write port loads
// either register, chosen by wr_sel. The new contents are visible from the
// cycle after the write. Assumes a synchronous active-low reset.
module dbp_regs #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value_q,
    output logic [W-1:0] mask_q
);

    // Loads the value register when the value register is selected
    always_ff @(posedge clk) begin
        if (!rst_n)                value_q <= '0;
        else if (wr_en && !wr_sel) value_q <= wr_data;
    end

    // Loads the mask register when the mask register is selected
    always_ff @(posedge clk) begin
        if (!rst_n)               mask_q <= '0;
        else if (wr_en && wr_sel) mask_q <= wr_data;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (value_q == '0 && mask_q == '0));

    p_value_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (value_q == $past(wr_data) && $stable(mask_q)));

    p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (mask_q == $past(wr_data) && $stable(value_q)));

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(value_q) && $stable(mask_q)));

endmodule

// File: rtl/dbp_lane_extract.sv
// Module dbp_lane_extract
// Pulls the operand out of the big-endian byte lanes chosen by address and
// size, and right-justifies it with zero extension. It also gives the set
// of result bits that take part in the comparison. Purely combinational.
// For word accesses only the upper address bit selects the half.
module dbp_lane_extract
    import dbp_pkg::*;
#(
    parameter int unsigned W  = BUS_W,
    parameter int unsigned LW = LANE_W
) (
    input  logic [W-1:0]                   data_i,
    input  logic [$clog2(W/LW)-1:0]        addr_i,
    input  logic [1:0]                     size_i,
    output logic [W-1:0]                   operand_o,
    output logic [W-1:0]                   relevant_o
);

    localparam int unsigned NL  = W / LW;
    localparam int unsigned AW  = $clog2(NL);
    localparam int unsigned HW  = W / 2;

    logic [LW-1:0] lane   [NL];
    logic [HW-1:0] half_hi;
    logic [HW-1:0] half_lo;
    logic [LW-1:0] byte_sel;
    logic [HW-1:0] word_sel;

    // Lane 0 is the most significant byte of the bus (big-endian)
    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign lane[g] = data_i[(NL-1-g)*LW +: LW];
    end

    assign half_hi = data_i[W-1:HW];
    assign half_lo = data_i[HW-1:0];

    // Selects the addressed byte lane
    always_comb begin
        byte_sel = lane[addr_i];
    end

    // Selects the addressed word half from the upper address bit only
    always_comb begin
        word_sel = addr_i[AW-1] ? half_lo : half_hi;
    end

    // Right-justifies the operand and marks the bits that are compared
    always_comb begin
        case (acc_size_e'(size_i))
            SZ_BYTE: begin
                operand_o  = W'(byte_sel);
                relevant_o = W'({LW{1'b1}});
            end
            SZ_WORD: begin
                operand_o  = W'(word_sel);
                relevant_o = W'({HW{1'b1}});
            end
            default: begin
                operand_o  = data_i;
                relevant_o = '1;
            end
        endcase
    end

endmodule

// File: rtl/dbp_compare.sv
// Module dbp_compare
// Masked equality between the extracted operand and the breakpoint value.
// The result is registered, so a qualifying transfer gives a one-clock
// pulse in the next cycle. Assumes the operand is already right-justified.
module dbp_compare #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic         enable_i,
    input  logic [W-1:0] operand_i,
    input  logic [W-1:0] relevant_i,
    input  logic [W-1:0] value_i,
    input  logic [W-1:0] mask_i,
    output logic         match_o
);

    logic [W-1:0] diff;
    logic         hit;

    // Flags each live bit where the operand and the value disagree
    always_comb begin
        diff = (operand_i ^ value_i) & ~mask_i & relevant_i;
        hit  = ~|diff;
    end

    // Registers the qualified match for one clock
    always_ff @(posedge clk) begin
        if (!rst_n) match_o <= 1'b0;
        else        match_o <= valid_i && enable_i && hit;
    end

    p_no_match_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !match_o);

    p_no_match_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !match_o);

    p_mask_all_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && enable_i && (&mask_i)) |=> match_o);

endmodule

// File: rtl/dbp_match_unit.sv
// Module dbp_match_unit
// Top of the data breakpoint comparator: the register file, the lane
// extractor and the registered masked compare. Assumes one bus transfer
// per clock at most, with all transfer inputs valid with xfer_valid.
module dbp_match_unit
    import dbp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [BUS_W-1:0]    wr_data,
    input  logic                bp_enable,
    input  logic                xfer_valid,
    input  logic [BUS_W-1:0]    xfer_data,
    input  logic [ADDR_W-1:0]   xfer_addr,
    input  logic [1:0]          xfer_size,
    output logic                bp_match
);

    logic [BUS_W-1:0] value_q;
    logic [BUS_W-1:0] mask_q;
    logic [BUS_W-1:0] operand;
    logic [BUS_W-1:0] relevant;

    dbp_regs #(.W(BUS_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .value_q (value_q),
        .mask_q  (mask_q)
    );

    dbp_lane_extract #(.W(BUS_W), .LW(LANE_W)) u_extract (
        .data_i     (xfer_data),
        .addr_i     (xfer_addr),
        .size_i     (xfer_size),
        .operand_o  (operand),
        .relevant_o (relevant)
    );

    dbp_compare #(.W(BUS_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (xfer_valid),
        .enable_i   (bp_enable),
        .operand_i  (operand),
        .relevant_i (relevant),
        .value_i    (value_q),
        .mask_i     (mask_q),
        .match_o    (bp_match)
    );

    p_byte_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_size == 2'b01) |-> (operand[BUS_W-1:LANE_W] == '0));

    p_word_a0_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_size == 2'b10) |->
            (operand[15:0] == (xfer_addr[1] ? xfer_data[15:0] : xfer_data[31:16])));

endmodule

// File: tb/dbp_match_unit_tb.sv
module dbp_match_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_sel, bp_enable, xfer_valid;
    logic [31:0] wr_data, xfer_data;
    logic [1:0]  xfer_addr, xfer_size;
    logic        bp_match;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    logic [31:0] m_val = '0;
    logic [31:0] m_msk = '0;
    int unsigned seed_dummy;

    always #2 clk = ~clk;

    dbp_match_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bp_enable(bp_enable), .xfer_valid(xfer_valid),
        .xfer_data(xfer_data), .xfer_addr(xfer_addr), .xfer_size(xfer_size),
        .bp_match(bp_match)
    );

    function automatic logic model_match(input logic [31:0] d, input logic [1:0] a,
                                         input logic [1:0] s, input logic [31:0] v,
                                         input logic [31:0] m);
        logic [31:0] op, rel;
        case (s)
            2'b01: begin op = (d >> (8 * (3 - a))) & 32'hFF; rel = 32'hFF; end
            2'b10: begin op = a[1] ? {16'h0, d[15:0]} : {16'h0, d[31:16]}; rel = 32'hFFFF; end
            default: begin op = d; rel = 32'hFFFF_FFFF; end
        endcase
        return (((op ^ v) & ~m & rel) == 32'h0);
    endfunction

    // Places operand x into the lane chosen by a and s, other lanes random
    function automatic logic [31:0] place(input logic [31:0] x, input logic [1:0] a,
                                          input logic [1:0] s, input logic [31:0] junk);
        logic [31:0] d;
        d = junk;
        case (s)
            2'b01: d[8*(3-a) +: 8] = x[7:0];
            2'b10: if (a[1]) d[15:0] = x[15:0]; else d[31:16] = x[15:0];
            default: d = x;
        endcase
        return d;
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: bp_match=%0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; xfer_valid = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_msk = d; else m_val = d;
    endtask

    // Drives one transfer and checks the registered result one cycle later
    task automatic xfer(input logic vld, input logic en, input logic [31:0] d,
                        input logic [1:0] a, input logic [1:0] s, input string tag);
        logic e;
        xfer_valid = vld; bp_enable = en; xfer_data = d; xfer_addr = a; xfer_size = s;
        e = vld && en && model_match(d, a, s, m_val, m_msk);
        @(negedge clk);
        xfer_valid = 1'b0;
        check(bp_match, e, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        bp_enable = 1'b0; xfer_valid = 1'b0; xfer_data = '0;
        xfer_addr = '0; xfer_size = '0;
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        check(bp_match, 1'b0, "R1 match low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(bp_match, 1'b0, "R1 match low after reset");
        // R1: zero value and mask -> zero longword matches, any other bit misses
        xfer(1, 1, 32'h0, 2'b00, 2'b00, "R1 zero regs match zero");
        xfer(1, 1, 32'h8000_0000, 2'b00, 2'b00, "R1 zero regs miss");

        // R8: same-cycle write uses old value, next cycle uses new
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'hDEAD_BEEF;
        xfer_valid = 1'b1; bp_enable = 1'b1; xfer_data = 32'hDEAD_BEEF;
        xfer_addr = 2'b00; xfer_size = 2'b00;
        @(negedge clk);
        wr_en = 1'b0; xfer_valid = 1'b0;
        check(bp_match, 1'b0, "R8 write not seen by same-cycle transfer");
        m_val = 32'hDEAD_BEEF;
        xfer(1, 1, 32'hDEAD_BEEF, 2'b10, 2'b00, "R8 R2 new value seen next cycle");
        xfer(0, 1, 32'hDEAD_BEEF, 2'b00, 2'b00, "R7 one-clock pulse, no valid");
        xfer(1, 1, 32'hDEAD_BEEF, 2'b01, 2'b11, "R2 reserved size as longword");
        xfer(1, 0, 32'hDEAD_BEEF, 2'b00, 2'b00, "R9 disabled");

        // R3: mask low nibble
        reg_write(1'b1, 32'h0000_000F);
        xfer(1, 1, 32'hDEAD_BEE0, 2'b00, 2'b00, "R3 masked bits ignored");
        xfer(1, 1, 32'hDEAD_BEFF, 2'b00, 2'b00, "R3 live bit compared");

        // R5, R6: byte lanes with junk in upper register bits
        reg_write(1'b0, 32'h1234_56A5);
        reg_write(1'b1, 32'h0000_0000);
        for (int a = 0; a < 4; a++)
            xfer(1, 1, 32'hA5 << (8 * (3 - a)), 2'(a), 2'b01, "R5 R6 byte lane");
        xfer(1, 1, 32'h00A5_0000, 2'b00, 2'b01, "R5 wrong lane miss");

        // R4: word halves, A0 ignored
        reg_write(1'b0, 32'hFFFF_C0DE);
        xfer(1, 1, 32'hC0DE_0000, 2'b01, 2'b10, "R4 upper half, A0 ignored");
        xfer(1, 1, 32'h0000_C0DE, 2'b11, 2'b10, "R4 lower half, A0 ignored");
        xfer(1, 1, 32'h0000_C0DE, 2'b00, 2'b10, "R4 wrong half miss");

        // Random phase
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  s, a;
            logic [31:0] d;
            string tag;
            if (i % 40 == 0) begin
                reg_write(1'b0, $urandom());
                reg_write(1'b1, $urandom() & $urandom());
            end
            s = 2'($urandom_range(0, 3));
            a = 2'($urandom_range(0, 3));
            d = $urandom();
            if ($urandom_range(0, 1) == 1) d = place(m_val, a, s, d);
            tag = (s == 2'b01) ? "R5 R6 R3 random byte" :
                  (s == 2'b10) ? "R4 R6 R3 random word" : "R2 R3 random long";
            xfer($urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0, d, a, s,
                 "R7 R9 random");
            xfer(1, 1, d, a, s, tag);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule